// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns one asynchronous serial receive line into parallel words. A sample-rate enable, `smp_tick`, comes from an external baud generator. Each tick takes one sample of the line after a two-flop synchronizer. A mode input selects between sixteen samples per bit and eight samples per bit.

In idle, the receiver looks for a falling edge. It confirms the start bit with a three-sample majority vote and drops short low pulses as noise. It aligns its bit-phase counter to every accepted start bit. It then decides each data bit, the optional parity bit and the first stop bit by a majority of the three samples at the centre of the bit.

Each finished frame gives a one-cycle valid strobe together with the word, a parity mismatch flag and a framing flag. The data length and the parity setting are captured when a start edge is seen, so they stay fixed for the whole frame.

Top module: `ovs_uart_rx`

## Requirements
- R1: While `rst` is high and after it is released, `rx_valid`, `rx_data`, `rx_par_err` and `rx_frm_err` are all 0 until a frame completes.
- R2: The line is sampled only on clock cycles where `smp_tick` is 1. Every `rx_valid` pulse follows a cycle in which `smp_tick` was 1.
- R3: In idle, a sample of 0 that follows a sample of 1 starts start-bit detection. That low sample counts as sample 1.
- R4: The start bit is judged on samples 8, 9 and 10 when `cfg_dbl`=0, and on samples 4, 5 and 6 when `cfg_dbl`=1. If two or more of these samples are 1, the edge is dropped, no word is delivered, and the receiver waits for a new falling edge.
- R5: Each data bit, the parity bit and the stop bit is the majority of its three centre samples: samples 8, 9 and 10 of 16, or samples 4, 5 and 6 of 8. A single inverted centre sample does not change the bit.
- R6: Data bits arrive least significant bit first into `rx_data[0]` upward. `cfg_bits` gives the length. Values below 5 act as 5 and values above 9 act as 9. Bits of `rx_data` above the length read 0.
- R7: `cfg_par` selects parity: 2'b01 even, 2'b10 odd, 2'b00 or 2'b11 none. `rx_par_err` is 1 when the received parity bit differs from the expected one. With parity off, no parity bit is taken and `rx_par_err` is 0.
- R8: A stop bit voted 0 sets `rx_frm_err`, and the word is still delivered with `rx_valid`.
- R9: After the stop-bit vote the receiver returns to idle at once. A start edge seen on the next tick is accepted, and any further stop bits are ignored.
- R10: The double-speed mode (`cfg_dbl`=1) receives correctly framed words at eight ticks per bit.
- R11: `rx_valid` lasts exactly one clock cycle. `rx_data` and the flags hold their values until the next delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_tick | input | 1 | Sample-rate enable, one cycle per sample |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_dbl | input | 1 | 0: 16 samples per bit, 1: 8 samples per bit |
| cfg_bits | input | 4 | Data length, 5 to 9 |
| cfg_par | input | 2 | Parity: 01 even, 10 odd, 00/11 none |
| rx_data | output | 9 | Received word, LSB first on the line |
| rx_valid | output | 1 | One-cycle strobe for a finished frame |
| rx_par_err | output | 1 | Parity mismatch for the delivered word |
| rx_frm_err | output | 1 | Stop bit voted 0 for the delivered word |

## Verification
The hardest case to reach from the ports is the boundary of the start-bit vote. There, a low pulse of exactly seven, eight or nine samples decides between rejection and acceptance. The bench aligns every line change to the tick that follows, so it controls each sample number exactly. It then sends pulses of those lengths and checks that none or one word comes out. The same sample control inverts only the middle centre sample of a chosen bit. It also ends a stop bit right after its vote and starts the next frame on the next tick, which tests the early restart.

// File: rtl/urx_pkg.sv
package urx_pkg;

    localparam int OSR_DEF  = 16;
    localparam int MAX_BITS = 9;
    localparam int MIN_BITS = 5;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_OFF2 = 2'b11
    } par_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } st_e;

    typedef struct packed {
        logic       dbl;
        logic [3:0] nbits;
        par_e       par;
    } cfg_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic [3:0] clamp_bits(input logic [3:0] n);
        if (n < 4'(MIN_BITS)) return 4'(MIN_BITS);
        if (n > 4'(MAX_BITS)) return 4'(MAX_BITS);
        return n;
    endfunction

    function automatic logic par_on(input par_e p);
        return (p == PAR_EVEN) || (p == PAR_ODD);
    endfunction

    function automatic logic par_expect(input logic [MAX_BITS-1:0] d, input par_e p);
        return (p == PAR_ODD) ? ~(^d) : (^d);
    endfunction

endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/urx_phase.sv
module urx_phase #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic restart,
    input  logic dbl,
    input  logic line,
    output logic prev_smp,
    output logic vote_evt,
    output logic vote_bit
);
    localparam int PW = $clog2(OSR + 1);
    localparam logic [PW-1:0] LAST_N = PW'(OSR);
    localparam logic [PW-1:0] LAST_D = PW'(OSR / 2);
    localparam logic [PW-1:0] CTR_N  = PW'(OSR / 2);
    localparam logic [PW-1:0] CTR_D  = PW'(OSR / 4);

    logic [PW-1:0] ph;
    logic [PW-1:0] nxt;
    logic [PW-1:0] last_s;
    logic [PW-1:0] ctr;
    logic          s_a, s_b;

    always_comb begin
        last_s = dbl ? LAST_D : LAST_N;
        ctr    = dbl ? CTR_D  : CTR_N;
        nxt    = (ph >= last_s) ? PW'(1) : ph + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PW'(1);
            s_a      <= 1'b1;
            s_b      <= 1'b1;
            prev_smp <= 1'b1;
        end else if (tick) begin
            prev_smp <= line;
            ph       <= restart ? PW'(1) : nxt;
            if (nxt == ctr)          s_a <= line;
            if (nxt == ctr + PW'(1)) s_b <= line;
        end
    end

    assign vote_evt = tick && !restart && (nxt == ctr + PW'(2));
    assign vote_bit = urx_pkg::maj3(s_a, s_b, line);
endmodule

// File: rtl/urx_frame.sv
module urx_frame
    import urx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                line,
    input  logic                prev_smp,
    input  logic                vote_evt,
    input  logic                vote_bit,
    input  cfg_t                cfg_in,
    output logic                restart,
    output cfg_t                cfg_q,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_valid,
    output logic                rx_par_err,
    output logic                rx_frm_err
);
    st_e                 st;
    logic [3:0]          idx;
    logic [MAX_BITS-1:0] shreg;
    logic                par_bit;

    assign restart = (st == ST_IDLE) && tick && prev_smp && !line;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            idx        <= '0;
            shreg      <= '0;
            par_bit    <= 1'b0;
            cfg_q      <= '{dbl: 1'b0, nbits: 4'(MAX_BITS), par: PAR_NONE};
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            rx_par_err <= 1'b0;
            rx_frm_err <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            unique case (st)
                ST_IDLE: if (restart) begin
                    st          <= ST_START;
                    cfg_q.dbl   <= cfg_in.dbl;
                    cfg_q.nbits <= clamp_bits(cfg_in.nbits);
                    cfg_q.par   <= cfg_in.par;
                    idx         <= '0;
                    shreg       <= '0;
                end
                ST_START: if (vote_evt) begin
                    st <= vote_bit ? ST_IDLE : ST_DATA;
                end
                ST_DATA: if (vote_evt) begin
                    shreg[idx] <= vote_bit;
                    if (idx == cfg_q.nbits - 4'd1)
                        st <= par_on(cfg_q.par) ? ST_PAR : ST_STOP;
                    else
                        idx <= idx + 4'd1;
                end
                ST_PAR: if (vote_evt) begin
                    par_bit <= vote_bit;
                    st      <= ST_STOP;
                end
                ST_STOP: if (vote_evt) begin
                    rx_data    <= shreg;
                    rx_valid   <= 1'b1;
                    rx_par_err <= par_on(cfg_q.par) &&
                                  (par_bit != par_expect(shreg, cfg_q.par));
                    rx_frm_err <= !vote_bit;
                    st         <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ovs_uart_rx.sv
module ovs_uart_rx
    import urx_pkg::*;
#(
    parameter int OSR       = OSR_DEF,
    parameter int SYNC_DEPTH = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_tick,
    input  logic                rx_line,
    input  logic                cfg_dbl,
    input  logic [3:0]          cfg_bits,
    input  logic [1:0]          cfg_par,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_valid,
    output logic                rx_par_err,
    output logic                rx_frm_err
);
    logic line_s;
    logic prev_smp, vote_evt, vote_bit, restart;
    cfg_t cfg_in, cfg_q;
    logic [1:0] par_cfg_q;

    assign cfg_in    = '{dbl: cfg_dbl, nbits: cfg_bits, par: par_e'(cfg_par)};
    assign par_cfg_q = cfg_q.par;

    urx_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (rx_line),
        .dout(line_s)
    );

    urx_phase #(.OSR(OSR)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .tick    (smp_tick),
        .restart (restart),
        .dbl     (cfg_q.dbl),
        .line    (line_s),
        .prev_smp(prev_smp),
        .vote_evt(vote_evt),
        .vote_bit(vote_bit)
    );

    urx_frame u_frame (
        .clk       (clk),
        .rst       (rst),
        .tick      (smp_tick),
        .line      (line_s),
        .prev_smp  (prev_smp),
        .vote_evt  (vote_evt),
        .vote_bit  (vote_bit),
        .cfg_in    (cfg_in),
        .restart   (restart),
        .cfg_q     (cfg_q),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err)
    );
endmodule

// File: rtl/ovs_uart_rx_chk.sv
module ovs_uart_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       smp_tick,
    input logic [8:0] rx_data,
    input logic       rx_valid,
    input logic       rx_par_err,
    input logic       rx_frm_err,
    input logic [1:0] par_cfg_q
);
    // R11
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R2
    valid_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(smp_tick));

    // R11
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> ($stable(rx_data) && $stable(rx_par_err) && $stable(rx_frm_err)));

    // R7
    no_par_err_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && (par_cfg_q == 2'b00 || par_cfg_q == 2'b11)) |-> !rx_par_err);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!rx_valid && rx_data == 9'd0 && !rx_par_err && !rx_frm_err));
endmodule

bind ovs_uart_rx ovs_uart_rx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_tick  (smp_tick),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .rx_par_err(rx_par_err),
    .rx_frm_err(rx_frm_err),
    .par_cfg_q (par_cfg_q)
);

// File: tb/test_ovs_uart_rx.sv
module test_ovs_uart_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_tick;
    logic       rx_line = 1'b1;
    logic       cfg_dbl = 1'b0;
    logic [3:0] cfg_bits = 4'd8;
    logic [1:0] cfg_par = 2'b00;
    logic [8:0] rx_data;
    logic       rx_valid, rx_par_err, rx_frm_err;

    int n_chk = 0;
    int n_bad = 0;
    int got_cnt = 0;
    logic [10:0] hist [0:63];
    logic [1:0]  tcnt;

    always #2 clk = ~clk;

    ovs_uart_rx i_ovs_uart_rx (
        .clk(clk), .rst(rst), .smp_tick(smp_tick), .rx_line(rx_line),
        .cfg_dbl(cfg_dbl), .cfg_bits(cfg_bits), .cfg_par(cfg_par),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
    );

    always @(posedge clk) begin
        if (rst) tcnt <= 2'd0;
        else     tcnt <= tcnt + 2'd1;
    end
    assign smp_tick = (tcnt == 2'd3);

    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            hist[got_cnt[5:0]] = {rx_frm_err, rx_par_err, rx_data};
            got_cnt = got_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (smp_tick !== 1'b1);
        @(negedge clk);
    endtask

    task automatic hold(input logic v, input int n);
        rx_line = v;
        for (int i = 0; i < n; i++) wait_tick();
    endtask

    // [0] dbl, [4:1] bits, [6:5] parity, [15:7] data, [16] flip parity, [17] stop, [21:18] glitch symbol (15 none)
    localparam int NV = 9;
    localparam logic [21:0] VEC [NV] = '{
        {4'd15, 1'b1, 1'b0, 9'h0A5, 2'b00, 4'd8, 1'b0},
        {4'd15, 1'b1, 1'b0, 9'h03C, 2'b01, 4'd8, 1'b0},
        {4'd15, 1'b1, 1'b1, 9'h03C, 2'b10, 4'd8, 1'b0},
        {4'd15, 1'b0, 1'b0, 9'h015, 2'b01, 4'd5, 1'b0},
        {4'd3,  1'b1, 1'b0, 9'h1A3, 2'b10, 4'd9, 1'b0},
        {4'd15, 1'b1, 1'b0, 9'h055, 2'b00, 4'd7, 1'b1},
        {4'd1,  1'b1, 1'b1, 9'h0F0, 2'b01, 4'd9, 1'b1},
        {4'd15, 1'b1, 1'b0, 9'h03B, 2'b00, 4'd4, 1'b0},
        {4'd15, 1'b0, 1'b0, 9'h02A, 2'b10, 4'd6, 1'b1}
    };

    function automatic int eff_bits(input logic [3:0] nb);
        if (nb < 4'd5) return 5;
        if (nb > 4'd9) return 9;
        return int'(nb);
    endfunction

    function automatic logic [8:0] exp_word(input logic [8:0] d, input logic [3:0] nb);
        return d & ((9'h1 << eff_bits(nb)) - 9'h1);
    endfunction

    task automatic send_frame(input logic dbl, input logic [3:0] nb, input logic [1:0] par,
                              input logic [8:0] d, input logic flip, input logic stopv,
                              input int gsym, input int stop_len, input int idle_after);
        logic sym [0:11];
        int   ns, nsmp, ctr, eb;
        logic [8:0] w;
        nsmp = dbl ? 8 : 16;
        ctr  = dbl ? 4 : 8;
        eb   = eff_bits(nb);
        w    = exp_word(d, nb);
        cfg_dbl = dbl; cfg_bits = nb; cfg_par = par;
        sym[0] = 1'b0;
        ns = 1;
        for (int i = 0; i < eb; i++) begin sym[ns] = w[i]; ns++; end
        if (par == 2'b01 || par == 2'b10) begin
            sym[ns] = ((par == 2'b10) ? ~(^w) : (^w)) ^ flip;
            ns++;
        end
        sym[ns] = stopv;
        ns++;
        for (int s = 0; s < ns; s++) begin
            int len;
            len = (s == ns - 1) ? stop_len : nsmp;
            for (int k = 1; k <= len; k++) begin
                logic v;
                v = sym[s];
                if (s == gsym && k == ctr + 1) v = ~v;
                hold(v, 1);
            end
        end
        hold(1'b1, idle_after);
    endtask

    initial begin
        int base;
        repeat (6) @(negedge clk);
        // R1: reset state
        chk("R1 valid in reset", rx_valid, 0);
        chk("R1 data in reset", rx_data, 0);
        chk("R1 flags in reset", {rx_par_err, rx_frm_err}, 0);
        rst = 1'b0;
        hold(1'b1, 4);
        chk("R1 valid after reset", rx_valid, 0);
        chk("R1 data after reset", rx_data, 0);

        // table walk: R2 R5 R6 R7 R8 R10
        for (int v = 0; v < NV; v++) begin
            logic [21:0] e;
            logic        dbl;
            e = VEC[v];
            dbl = e[0];
            base = got_cnt;
            send_frame(dbl, e[4:1], e[6:5], e[15:7], e[16], e[17],
                       (e[21:18] == 4'd15) ? -1 : int'(e[21:18]),
                       dbl ? 8 : 16, 4);
            chk($sformatf("R2 R10 one word row %0d", v), got_cnt - base, 1);
            chk($sformatf("R5 R6 data row %0d", v), hist[base[5:0]][8:0], exp_word(e[15:7], e[4:1]));
            chk($sformatf("R7 parity flag row %0d", v), hist[base[5:0]][9],
                e[16] && (e[6:5] == 2'b01 || e[6:5] == 2'b10));
            chk($sformatf("R8 framing flag row %0d", v), hist[base[5:0]][10], !e[17]);
        end

        // R4: start-vote boundary, normal mode
        cfg_dbl = 1'b0; cfg_bits = 4'd8; cfg_par = 2'b00;
        base = got_cnt;
        hold(1'b0, 7); hold(1'b1, 40);
        chk("R4 low 7 samples rejected", got_cnt - base, 0);
        hold(1'b0, 8); hold(1'b1, 40);
        chk("R4 low 8 samples rejected", got_cnt - base, 0);
        // R3 R4: low 9 samples accepted, rest high gives all ones
        hold(1'b0, 9); hold(1'b1, 160);
        chk("R4 low 9 samples accepted", got_cnt - base, 1);
        chk("R3 all-ones word", hist[base[5:0]], 11'h0FF);

        // R4 R10: double mode boundary
        cfg_dbl = 1'b1;
        base = got_cnt;
        hold(1'b0, 4); hold(1'b1, 30);
        chk("R4 double low 4 rejected", got_cnt - base, 0);
        hold(1'b0, 5); hold(1'b1, 90);
        chk("R4 double low 5 accepted", got_cnt - base, 1);

        // R9: stop cut right after its vote, next start on next tick, extra stop ignored
        base = got_cnt;
        send_frame(1'b0, 4'd8, 2'b01, 9'h0C3, 1'b0, 1'b1, -1, 10, 0);
        send_frame(1'b0, 4'd8, 2'b01, 9'h05A, 1'b0, 1'b1, -1, 16, 0);
        send_frame(1'b0, 4'd8, 2'b00, 9'h0E1, 1'b0, 1'b1, -1, 16, 40);
        chk("R9 three back-to-back words", got_cnt - base, 3);
        chk("R9 first word", hist[base[5:0]], 11'h0C3);
        chk("R9 second word", hist[6'(base + 1)], 11'h05A);
        chk("R9 third word", hist[6'(base + 2)], 11'h0E1);
        // R11: outputs held after strobe
        hold(1'b1, 20);
        chk("R11 data held", rx_data, 9'h0E1);
        chk("R11 valid low", rx_valid, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule